// File: doc/BRIEF.md
# Masked Two-Lane FP64 Dot-Product Unit

This block forms a dot product of two 128-bit operands. Each operand carries two IEEE-754 binary64 lanes: bits [63:0] are the low lane and bits [127:64] are the high lane. A control byte decides two things: which of the two lane products enter the sum, and which result lanes receive that sum. A product that is switched off is replaced by +0.0 and cannot raise any flag. A result lane that is not selected is written as +0.0. The arithmetic is the block's own. It rounds to nearest-even and flushes subnormal values to signed zero. A single multiplier serves both lanes over two successive cycles, and one adder follows it.

A request is a one-cycle `start_i` pulse that arrives while the unit is idle. The request carries the operands, the control byte, an encoding-mode bit, a vector-length bit, a per-flag mask and the upper part of the wider destination. The unit returns a 128-bit result, the upper destination part and a one-cycle `done_o`. It also keeps five sticky exception flags. When a raised flag is not masked, `exc_o` pulses alongside `done_o` and the destination keeps its previous value. A request that carries a vector-length bit of 1 is refused. In that case `ud_o` pulses and nothing is computed.

Top module: `dpp_dot2`

## Requirements
- R1: Control bit 4 set: the low term is opa[63:0]*opb[63:0]. Control bit 4 clear: the low term is +0.0, and that product contributes no flag.
- R2: Control bit 5 set: the high term is opa[127:64]*opb[127:64]. Control bit 5 clear: the high term is +0.0, and that product contributes no flag.
- R3: The two terms are added into one binary64 sum. Control bit 0 writes that sum to res[63:0] and control bit 1 writes it to res[127:64]. A result lane whose bit is clear becomes +0.0.
- R4: Control bits 2, 3, 6 and 7 have no effect on the result or on the flags.
- R5: Every product and the sum are rounded to nearest, ties to even. Any discarded nonzero bit sets the precision flag.
- R6: A subnormal input sets the denormal flag and is used as a signed zero. A rounded result exponent below the normal range gives signed zero with underflow and precision set. A rounded result exponent above the normal range gives a signed infinity with overflow and precision set.
- R7: A NaN input is passed on with its quiet bit (bit 51) set, and the first operand takes precedence. A signalling NaN input sets the invalid flag. Infinity times zero, and infinities of opposite sign added together, each give the default NaN 0xFFF8000000000000 and set the invalid flag.
- R8: flags_o holds invalid at bit 0, denormal at bit 1, overflow at bit 2, underflow at bit 3 and precision at bit 4. Each completed operation ORs its flags into flags_o. Bits never clear except at reset.
- R9: xmask_i uses the same bit positions as flags_o, and a 1 masks that flag. If an operation raises a flag whose mask bit is 0, exc_o pulses together with done_o and res_o and res_up_o keep their old values. The flags still accumulate.
- R10: With vex_i = 0, res_up_o takes the dst_up_i value captured at start. With vex_i = 1, res_up_o becomes zero.
- R11: A start with vlen_i = 1 while idle makes ud_o pulse for one cycle in the cycle after the start edge. That request produces no done_o and leaves res_o, res_up_o and flags_o unchanged.
- R12: If start_i is sampled high at rising edge k while idle, done_o is high for exactly one cycle, from edge k+3 to edge k+4. Any start arriving while an operation is in progress is ignored.
- R13: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; sampled only while idle |
| opa_i | input | 128 | First operand, two binary64 lanes |
| opb_i | input | 128 | Second operand, two binary64 lanes |
| ctrl_i | input | 8 | Term enables in bits 5:4, lane selects in bits 1:0 |
| vex_i | input | 1 | 1: upper destination zeroed; 0: passed through |
| vlen_i | input | 1 | Vector-length bit; 1 refuses the request |
| xmask_i | input | 5 | Per-flag mask, 1 = masked |
| dst_up_i | input | UPPER_W (128) | Upper part of the destination before the operation |
| res_o | output | 128 | Result lanes |
| res_up_o | output | UPPER_W (128) | Upper part of the destination after the operation |
| done_o | output | 1 | One-cycle completion pulse |
| exc_o | output | 1 | Unmasked exception; destination not written |
| ud_o | output | 1 | Request refused for the vector-length bit |
| flags_o | output | 5 | Sticky exception flags |

## Verification
The timing assertions look back a fixed four edges from `done_o`. They therefore rely on two things: the start behind a done pulse was the accepted one, and its `ctrl_i` and `vex_i` were valid at that edge. The bench meets both. It drives every input on the falling clock edge and holds each request's fields steady through its start edge. The NaN checks in the arithmetic modules assume the operands carry no unknown bits once reset has ended. The bench supplies fully defined binary64 patterns in every test.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int NLANE  = 2;
    localparam int NFLAG  = 5;
    localparam int VEC_W  = FP_W * NLANE;

    localparam int F_INV = 0;
    localparam int F_DEN = 1;
    localparam int F_OVF = 2;
    localparam int F_UNF = 3;
    localparam int F_PRE = 4;

    localparam logic [FP_W-1:0] QNAN_DFLT = 64'hFFF8_0000_0000_0000;

    typedef logic [NFLAG-1:0] flags_t;

    typedef struct packed {
        logic [FP_W-1:0] val;
        flags_t          flg;
    } fp_res_t;

    typedef enum logic [1:0] {ST_IDLE, ST_MUL_LO, ST_MUL_HI, ST_ADD} seq_t;

    function automatic logic is_nan(logic [FP_W-1:0] x);
        return (&x[62:52]) && (|x[51:0]);
    endfunction

    function automatic logic is_inf(logic [FP_W-1:0] x);
        return (&x[62:52]) && !(|x[51:0]);
    endfunction

    function automatic logic is_zsub(logic [FP_W-1:0] x);
        return !(|x[62:52]);
    endfunction

    function automatic logic is_sub(logic [FP_W-1:0] x);
        return !(|x[62:52]) && (|x[51:0]);
    endfunction

    function automatic logic is_snan(logic [FP_W-1:0] x);
        return is_nan(x) && !x[51];
    endfunction

    function automatic logic [FP_W-1:0] quiet(logic [FP_W-1:0] x);
        return x | 64'h0008_0000_0000_0000;
    endfunction

    // nearest-even rounding, then range check with flush to zero
    function automatic fp_res_t round_pack(logic s, logic signed [13:0] e,
                                           logic [FRAC_W:0] m, logic g, logic st);
        fp_res_t           r;
        logic              up;
        logic [FRAC_W+1:0] mr;
        logic signed [13:0] er;
        up = g & (st | m[0]);
        mr = {1'b0, m} + {{(FRAC_W+1){1'b0}}, up};
        er = e;
        if (mr[FRAC_W+1]) begin
            mr = mr >> 1;
            er = e + 14'sd1;
        end
        r.flg        = '0;
        r.flg[F_PRE] = g | st;
        if (er >= 14'sd2047) begin
            r.val        = {s, 11'h7FF, 52'd0};
            r.flg[F_OVF] = 1'b1;
            r.flg[F_PRE] = 1'b1;
        end else if (er <= 14'sd0) begin
            r.val        = {s, 63'd0};
            r.flg[F_UNF] = 1'b1;
            r.flg[F_PRE] = 1'b1;
        end else begin
            r.val = {s, er[EXP_W-1:0], mr[FRAC_W-1:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/dpp_fmul.sv
module dpp_fmul
    import dpp_pkg::*;
(
    input  logic [FP_W-1:0] a_i,
    input  logic [FP_W-1:0] b_i,
    output logic [FP_W-1:0] p_o,
    output flags_t          f_o
);

    localparam int PROD_W = 2 * (FRAC_W + 1);

    logic              a_nan, b_nan, a_inf, b_inf, a_zr, b_zr, sgn;
    logic [PROD_W-1:0] prod;
    logic signed [13:0] exp_d;
    logic [FRAC_W:0]   mant_d;
    logic              grd_d, stk_d;
    fp_res_t           rp;

    always_comb begin
        a_nan = is_nan(a_i);
        b_nan = is_nan(b_i);
        a_inf = is_inf(a_i);
        b_inf = is_inf(b_i);
        a_zr  = is_zsub(a_i);
        b_zr  = is_zsub(b_i);
        sgn   = a_i[FP_W-1] ^ b_i[FP_W-1];
        prod  = PROD_W'({1'b1, a_i[FRAC_W-1:0]}) * PROD_W'({1'b1, b_i[FRAC_W-1:0]});
        if (prod[PROD_W-1]) begin
            mant_d = prod[PROD_W-1 -: FRAC_W+1];
            grd_d  = prod[FRAC_W];
            stk_d  = |prod[FRAC_W-1:0];
        end else begin
            mant_d = prod[PROD_W-2 -: FRAC_W+1];
            grd_d  = prod[FRAC_W-1];
            stk_d  = |prod[FRAC_W-2:0];
        end
        exp_d = $signed({3'b000, a_i[62:52]}) + $signed({3'b000, b_i[62:52]})
              - 14'sd1023 + (prod[PROD_W-1] ? 14'sd1 : 14'sd0);
        rp    = round_pack(sgn, exp_d, mant_d, grd_d, stk_d);

        p_o = '0;
        f_o = '0;
        if (a_nan || b_nan) begin
            p_o        = a_nan ? quiet(a_i) : quiet(b_i);
            f_o[F_INV] = is_snan(a_i) | is_snan(b_i);
        end else begin
            f_o[F_DEN] = is_sub(a_i) | is_sub(b_i);
            if ((a_inf && b_zr) || (b_inf && a_zr)) begin
                p_o        = QNAN_DFLT;
                f_o[F_INV] = 1'b1;
            end else if (a_inf || b_inf) begin
                p_o = {sgn, 11'h7FF, 52'd0};
            end else if (a_zr || b_zr) begin
                p_o = {sgn, 63'd0};
            end else begin
                p_o = rp.val;
                f_o = f_o | rp.flg;
            end
        end
    end

    always_comb begin
        if (a_nan || b_nan) begin
            assert_mul_nan_R7: assert (is_nan(p_o));
        end
    end

endmodule

// File: rtl/dpp_fadd.sv
module dpp_fadd
    import dpp_pkg::*;
(
    input  logic [FP_W-1:0] a_i,
    input  logic [FP_W-1:0] b_i,
    output logic [FP_W-1:0] s_o,
    output flags_t          f_o
);

    localparam int EXT_W = FRAC_W + 4;

    function automatic logic [5:0] lzc(logic [EXT_W-1:0] x);
        logic [5:0] n;
        logic       hit;
        n   = '0;
        hit = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (x[i]) hit = 1'b1;
                else      n   = n + 6'd1;
            end
        end
        return n;
    endfunction

    logic              a_nan, b_nan, a_inf, b_inf, a_zr, b_zr;
    logic [FP_W-1:0]   big, sml;
    logic [EXP_W-1:0]  dexp;
    logic [EXT_W-1:0]  m_big, m_sml, m_al, n_m;
    logic [EXT_W:0]    sum;
    logic [5:0]        lz;
    logic              stk;
    logic signed [13:0] e_n;
    fp_res_t           rp;

    always_comb begin
        a_nan = is_nan(a_i);
        b_nan = is_nan(b_i);
        a_inf = is_inf(a_i);
        b_inf = is_inf(b_i);
        a_zr  = is_zsub(a_i);
        b_zr  = is_zsub(b_i);
        if (a_i[FP_W-2:0] >= b_i[FP_W-2:0]) begin
            big = a_i;
            sml = b_i;
        end else begin
            big = b_i;
            sml = a_i;
        end
        dexp  = big[62:52] - sml[62:52];
        m_big = {1'b1, big[FRAC_W-1:0], 3'b000};
        m_sml = {1'b1, sml[FRAC_W-1:0], 3'b000};
        if (dexp >= EXP_W'(EXT_W)) begin
            m_al = '0;
            stk  = 1'b1;
        end else begin
            m_al = m_sml >> dexp;
            stk  = |(m_sml & ((EXT_W'(1) << dexp) - EXT_W'(1)));
        end
        m_al[0] = m_al[0] | stk;
        if (big[FP_W-1] ^ sml[FP_W-1]) sum = {1'b0, m_big} - {1'b0, m_al};
        else                           sum = {1'b0, m_big} + {1'b0, m_al};
        lz = lzc(sum[EXT_W-1:0]);
        if (sum[EXT_W]) begin
            n_m    = sum[EXT_W:1];
            n_m[0] = n_m[0] | sum[0];
            e_n    = $signed({3'b000, big[62:52]}) + 14'sd1;
        end else begin
            n_m = sum[EXT_W-1:0] << lz;
            e_n = $signed({3'b000, big[62:52]}) - $signed({8'd0, lz});
        end
        rp = round_pack(big[FP_W-1], e_n, n_m[EXT_W-1:3], n_m[2], |n_m[1:0]);

        s_o = '0;
        f_o = '0;
        if (a_nan || b_nan) begin
            s_o        = a_nan ? quiet(a_i) : quiet(b_i);
            f_o[F_INV] = is_snan(a_i) | is_snan(b_i);
        end else begin
            f_o[F_DEN] = is_sub(a_i) | is_sub(b_i);
            if (a_inf && b_inf && (a_i[FP_W-1] != b_i[FP_W-1])) begin
                s_o        = QNAN_DFLT;
                f_o[F_INV] = 1'b1;
            end else if (a_inf) begin
                s_o = a_i;
            end else if (b_inf) begin
                s_o = b_i;
            end else if (a_zr && b_zr) begin
                s_o = {a_i[FP_W-1] & b_i[FP_W-1], 63'd0};
            end else if (a_zr) begin
                s_o = b_i;
            end else if (b_zr) begin
                s_o = a_i;
            end else if (sum == '0) begin
                s_o = '0;
            end else begin
                s_o = rp.val;
                f_o = f_o | rp.flg;
            end
        end
    end

    always_comb begin
        if (a_nan || b_nan) begin
            assert_add_nan_R7: assert (is_nan(s_o));
        end
    end

endmodule

// File: rtl/dpp_dot2.sv
module dpp_dot2
    import dpp_pkg::*;
#(
    parameter int UPPER_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [127:0]       opa_i,
    input  logic [127:0]       opb_i,
    input  logic [7:0]         ctrl_i,
    input  logic               vex_i,
    input  logic               vlen_i,
    input  logic [4:0]         xmask_i,
    input  logic [UPPER_W-1:0] dst_up_i,
    output logic [127:0]       res_o,
    output logic [UPPER_W-1:0] res_up_o,
    output logic               done_o,
    output logic               exc_o,
    output logic               ud_o,
    output logic [4:0]         flags_o
);

    typedef struct packed {
        seq_t               st;
        logic [VEC_W-1:0]   a;
        logic [VEC_W-1:0]   b;
        logic               en_lo;
        logic               en_hi;
        logic [NLANE-1:0]   bc;
        logic               vex;
        flags_t             mask;
        logic [UPPER_W-1:0] up_in;
        logic [FP_W-1:0]    t_lo;
        logic [FP_W-1:0]    t_hi;
        flags_t             opf;
        logic [VEC_W-1:0]   res;
        logic [UPPER_W-1:0] res_up;
        flags_t             flags;
        logic               done;
        logic               exc;
        logic               ud;
    } regs_t;

    regs_t           r_q, r_d;
    logic [FP_W-1:0] mul_a, mul_b, mul_p, add_s;
    flags_t          mul_f, add_f, all_f;
    logic [3:0]      unused_ctrl;

    assign unused_ctrl = {ctrl_i[7:6], ctrl_i[3:2]};

    // one multiplier, low lane then high lane
    assign mul_a = (r_q.st == ST_MUL_HI) ? r_q.a[VEC_W-1 -: FP_W] : r_q.a[FP_W-1:0];
    assign mul_b = (r_q.st == ST_MUL_HI) ? r_q.b[VEC_W-1 -: FP_W] : r_q.b[FP_W-1:0];

    dpp_fmul u_mul (.a_i(mul_a), .b_i(mul_b), .p_o(mul_p), .f_o(mul_f));
    dpp_fadd u_add (.a_i(r_q.t_lo), .b_i(r_q.t_hi), .s_o(add_s), .f_o(add_f));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.exc  = 1'b0;
        r_d.ud   = 1'b0;
        all_f    = r_q.opf | add_f;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (vlen_i) begin
                        r_d.ud = 1'b1;
                    end else begin
                        r_d.a     = opa_i;
                        r_d.b     = opb_i;
                        r_d.en_lo = ctrl_i[4];
                        r_d.en_hi = ctrl_i[5];
                        r_d.bc    = ctrl_i[1:0];
                        r_d.vex   = vex_i;
                        r_d.mask  = xmask_i;
                        r_d.up_in = dst_up_i;
                        r_d.opf   = '0;
                        r_d.st    = ST_MUL_LO;
                    end
                end
            end
            ST_MUL_LO: begin
                r_d.t_lo = r_q.en_lo ? mul_p : '0;
                if (r_q.en_lo) r_d.opf = r_q.opf | mul_f;
                r_d.st = ST_MUL_HI;
            end
            ST_MUL_HI: begin
                r_d.t_hi = r_q.en_hi ? mul_p : '0;
                if (r_q.en_hi) r_d.opf = r_q.opf | mul_f;
                r_d.st = ST_ADD;
            end
            default: begin
                r_d.flags = r_q.flags | all_f;
                r_d.done  = 1'b1;
                r_d.exc   = |(all_f & ~r_q.mask);
                if (!r_d.exc) begin
                    for (int l = 0; l < NLANE; l++) begin
                        r_d.res[l*FP_W +: FP_W] = r_q.bc[l] ? add_s : '0;
                    end
                    r_d.res_up = r_q.vex ? '0 : r_q.up_in;
                end
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_o    = r_q.res;
    assign res_up_o = r_q.res_up;
    assign done_o   = r_q.done;
    assign exc_o    = r_q.exc;
    assign ud_o     = r_q.ud;
    assign flags_o  = r_q.flags;

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i, 4));
    assert_ud_nodone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ud_o |-> !done_o);
    assert_ud_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ud_o |-> ($stable(res_o) && $stable(flags_o)));
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags_o) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
    assert_exc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> ($stable(res_o) && $stable(res_up_o) && done_o));
    assert_lane_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exc_o && !$past(ctrl_i[0], 4)) |-> (res_o[63:0] == 64'd0));
    assert_bcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exc_o && ($past(ctrl_i[1:0], 4) == 2'b11)) |-> (res_o[127:64] == res_o[63:0]));
    assert_vex_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exc_o && $past(vex_i, 4)) |-> (res_up_o == '0));

endmodule

// File: tb/dpp_dot2_bench.sv
module dpp_dot2_bench;

    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] THR  = 64'h4008_0000_0000_0000;
    localparam logic [63:0] FOUR = 64'h4010_0000_0000_0000;
    localparam logic [63:0] ONEH = 64'h3FF8_0000_0000_0000;
    localparam logic [63:0] TWLV = 64'h4028_0000_0000_0000;
    localparam logic [63:0] FRTN = 64'h402C_0000_0000_0000;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] DNAN = 64'hFFF8_0000_0000_0000;
    localparam logic [127:0] UPAT = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5A5A_A5A5;
    localparam logic [4:0]  ALLM = 5'b11111;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] opa = '0, opb = '0;
    logic [7:0]   ctrl = '0;
    logic         vex = 1'b0, vlen = 1'b0;
    logic [4:0]   xmask = ALLM;
    logic [127:0] dst_up = '0;
    logic [127:0] res_o, res_up_o;
    logic         done_o, exc_o, ud_o;
    logic [4:0]   flags_o;

    int checks = 0;
    int errors = 0;
    logic [4:0] exp_flags = '0;
    int   cyc;
    logic got_done, got_exc, got_ud;

    always #10 clk = ~clk;

    dpp_dot2 u_dpp_dot2 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .opa_i(opa), .opb_i(opb),
        .ctrl_i(ctrl), .vex_i(vex), .vlen_i(vlen), .xmask_i(xmask), .dst_up_i(dst_up),
        .res_o(res_o), .res_up_o(res_up_o), .done_o(done_o), .exc_o(exc_o),
        .ud_o(ud_o), .flags_o(flags_o)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [7:0] c,
                          input logic vx, input logic vl, input logic [4:0] m,
                          input logic [127:0] up);
        @(negedge clk);
        opa = a; opb = b; ctrl = c; vex = vx; vlen = vl; xmask = m; dst_up = up;
        start = 1'b1;
        cyc = 0; got_done = 1'b0; got_exc = 1'b0; got_ud = 1'b0;
        while (cyc < 20 && !got_done && !got_ud) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            got_done = done_o; got_exc = exc_o; got_ud = ud_o;
        end
    endtask

    task automatic op_ok(input string req, input logic [127:0] a, input logic [127:0] b,
                         input logic [7:0] c, input logic [127:0] exp_res, input logic [4:0] new_f);
        run_op(a, b, c, 1'b0, 1'b0, ALLM, '0);
        exp_flags = exp_flags | new_f;
        check({req, " done"}, {127'd0, got_done}, 128'd1);
        check({req, " result"}, res_o, exp_res);
        check({req, " R8 flags"}, {123'd0, flags_o}, {123'd0, exp_flags});
    endtask

    task automatic t_reset;
        check("R13 res", res_o, '0);
        check("R13 up", res_up_o, '0);
        check("R13 pulses", {125'd0, done_o, exc_o, ud_o}, '0);
        check("R13 flags", {123'd0, flags_o}, '0);
    endtask

    task automatic t_basic;
        op_ok("R3 both lanes", {THR, TWO}, {FOUR, ONE}, 8'h33, {FRTN, FRTN}, 5'd0);
        op_ok("R3 low lane only", {THR, TWO}, {FOUR, ONE}, 8'h31, {64'd0, FRTN}, 5'd0);
    endtask

    task automatic t_lanes;
        op_ok("R2 high term only", {THR, TWO}, {FOUR, ONE}, 8'h23, {TWLV, TWLV}, 5'd0);
        op_ok("R1 low term only", {THR, TWO}, {FOUR, ONE}, 8'h13, {TWO, TWO}, 5'd0);
        // inf*0 in the low lane is switched off: no invalid flag
        op_ok("R1 masked product no flag", {THR, PINF}, {FOUR, 64'd0}, 8'h23, {TWLV, TWLV}, 5'd0);
        op_ok("R2 masked product no flag", {PINF, TWO}, {64'd0, ONE}, 8'h13, {TWO, TWO}, 5'd0);
    endtask

    task automatic t_ignored;
        op_ok("R4 bits 2,3,6,7 set", {THR, TWO}, {FOUR, ONE}, 8'hFF, {FRTN, FRTN}, 5'd0);
        op_ok("R4 only ignored bits", {THR, TWO}, {FOUR, ONE}, 8'hCC, 128'd0, 5'd0);
    endtask

    task automatic t_mode;
        run_op({THR, TWO}, {FOUR, ONE}, 8'h33, 1'b0, 1'b0, ALLM, UPAT);
        check("R10 legacy upper kept", res_up_o, UPAT);
        run_op({THR, TWO}, {FOUR, ONE}, 8'h33, 1'b1, 1'b0, ALLM, UPAT);
        check("R10 vex upper zero", res_up_o, '0);
    endtask

    task automatic t_round;
        op_ok("R5 product above half", {64'd0, 64'h3FF0_0000_0000_0001}, {64'd0, 64'h3FF0_0000_0000_0001},
              8'h11, {64'd0, 64'h3FF0_0000_0000_0002}, 5'b10000);
        op_ok("R5 product tie up to even", {64'd0, 64'h3FF0_0000_0000_0001}, {64'd0, ONEH},
              8'h11, {64'd0, 64'h3FF8_0000_0000_0002}, 5'b10000);
        op_ok("R5 product tie down to even", {64'd0, 64'h3FF0_0000_0000_0003}, {64'd0, ONEH},
              8'h11, {64'd0, 64'h3FF8_0000_0000_0004}, 5'b10000);
        op_ok("R5 sum tie down", {64'h3CA0_0000_0000_0000, ONE}, {ONE, ONE},
              8'h31, {64'd0, ONE}, 5'b10000);
        op_ok("R5 sum tie up", {64'h3CA0_0000_0000_0000, 64'h3FF0_0000_0000_0001}, {ONE, ONE},
              8'h31, {64'd0, 64'h3FF0_0000_0000_0002}, 5'b10000);
    endtask

    task automatic t_range;
        op_ok("R6 denormal input", {64'd0, 64'h0000_0000_0000_0001}, {64'd0, TWO},
              8'h11, 128'd0, 5'b00010);
        op_ok("R6 overflow", {64'd0, 64'h7FE0_0000_0000_0000}, {64'd0, FOUR},
              8'h11, {64'd0, PINF}, 5'b10100);
        op_ok("R6 underflow signed zero", {64'h8170_0000_0000_0000, 64'h8170_0000_0000_0000},
              {64'h39B0_0000_0000_0000, 64'h39B0_0000_0000_0000}, 8'h33,
              {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000}, 5'b11000);
    endtask

    task automatic t_nan;
        op_ok("R7 quiet NaN passes", {ONE, 64'h7FF8_0000_0000_0001}, {ONE, ONE}, 8'h13,
              {64'h7FF8_0000_0000_0001, 64'h7FF8_0000_0000_0001}, 5'd0);
        op_ok("R7 signalling NaN quieted", {ONE, 64'h7FF0_0000_0000_0001}, {ONE, ONE}, 8'h11,
              {64'd0, 64'h7FF8_0000_0000_0001}, 5'b00001);
        op_ok("R7 inf times zero", {64'd0, PINF}, {64'd0, 64'd0}, 8'h11, {64'd0, DNAN}, 5'b00001);
        op_ok("R7 inf minus inf", {NINF, PINF}, {ONE, ONE}, 8'h31, {64'd0, DNAN}, 5'b00001);
    endtask

    task automatic t_unmasked;
        run_op({THR, TWO}, {FOUR, ONE}, 8'h33, 1'b0, 1'b0, ALLM, UPAT);
        run_op({64'd0, PINF}, {64'd0, 64'd0}, 8'h11, 1'b0, 1'b0, 5'b11110, 128'd5);
        check("R9 exc with done", {126'd0, got_done, got_exc}, 128'd3);
        check("R9 result held", res_o, {FRTN, FRTN});
        check("R9 upper held", res_up_o, UPAT);
        check("R9 flags still set", {123'd0, flags_o}, {123'd0, exp_flags | 5'b00001});
        run_op({THR, TWO}, {FOUR, ONE}, 8'h12, 1'b0, 1'b0, 5'b00000, '0);
        check("R9 clean op under no mask", {126'd0, got_done, got_exc}, 128'd2);
        check("R9 clean op result", res_o, {TWO, 64'd0});
    endtask

    task automatic t_ud;
        logic [127:0] prev;
        prev = res_o;
        run_op({THR, TWO}, {FOUR, ONE}, 8'h33, 1'b0, 1'b1, ALLM, '0);
        check("R11 ud pulse after one edge", {126'd0, got_ud, got_done}, 128'd2);
        check("R11 ud latency", 128'(cyc), 128'd1);
        repeat (5) begin
            @(negedge clk);
            if (done_o) got_done = 1'b1;
        end
        check("R11 no done", {127'd0, got_done}, 128'd0);
        check("R11 result unchanged", res_o, prev);
        check("R11 flags unchanged", {123'd0, flags_o}, {123'd0, exp_flags});
    endtask

    task automatic t_timing;
        int hi_cnt;
        int seen_at;
        @(negedge clk);
        opa = {THR, TWO}; opb = {FOUR, ONE}; ctrl = 8'h33; vlen = 1'b0; vex = 1'b0; xmask = ALLM;
        start = 1'b1;
        hi_cnt = 0; seen_at = 0; got_ud = 1'b0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            start = (i == 2);
            if (i == 2) begin
                ctrl = 8'h11; vlen = 1'b1;
            end else begin
                vlen = 1'b0;
            end
            if (done_o) begin
                hi_cnt++;
                if (seen_at == 0) seen_at = i;
                check("R12 result of first request", res_o, {FRTN, FRTN});
            end
            if (ud_o) got_ud = 1'b1;
        end
        check("R12 done after three edges", 128'(seen_at), 128'd4);
        check("R12 single done pulse", 128'(hi_cnt), 128'd1);
        check("R12 busy start ignored", {127'd0, got_ud}, 128'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_lanes();
        t_ignored();
        t_mode();
        t_round();
        t_range();
        t_nan();
        t_unmasked();
        exp_flags = exp_flags | 5'b00001;
        t_ud();
        t_timing();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule